// File: doc/BRIEF.md
# Macroblock Quantizer Step Controller

This block picks the quantizer step (QP, 1 to 31) for each macroblock of a video frame as the frame is being encoded. A frame-level allocator loads the frame's total complexity, its bit budget and a starting QP. For every macroblock after the first, the block compares what has been spent so far with what is left. The coded macroblocks give a used complexity, used bits and a QP sum. The rest of the frame gives a remaining complexity and remaining bits. From these the block forms a requested QP. It then applies the bitstream's syntax rules and returns the final QP.

The block computes the requested step as (remaining complexity × used bits × QP sum) / (used complexity × remaining bits × macroblocks coded). It uses a shift-subtract divider that takes several cycles. Once a macroblock has been coded, the encoder reports its complexity and its actual bit count. Inter macroblocks give their SAD as complexity, and intra macroblocks give their pixel deviation. The block adds both values to its running totals.

Top module: `mbq_ctrl`

## Requirements
- R1: After reset, `qp_valid` is 0 and `qp_out` is 0.
- R2: The first macroblock after `frm_start` receives the frame QP. A frame QP of 0 is raised to 1.
- R3: For a later macroblock, the block takes the requested QP as floor((remaining complexity × used bits × QP sum) / (used complexity × remaining bits × macroblocks coded)). A quotient above 31 becomes 31.
- R4: Apart from the first macroblock of a frame, the final QP differs from the previous macroblock's QP by at most 2.
- R5: A macroblock whose `mb_mode` is 2'b10 (not coded) or 2'b11 (inter with four vectors) receives the previous QP unchanged. Modes 2'b00 (inter) and 2'b01 (intra) follow the rate rule.
- R6: When the remaining bits are zero or negative, the requested QP is 31, and the ±2 limit then applies.
- R7: A `mb_done` pulse updates the totals. Remaining complexity falls by `mb_cplx` and saturates at 0. Remaining bits fall by `mb_bits` and may go negative. Used complexity and used bits rise by the same values. The QP sum rises by the QP last issued, and the macroblock count rises by one.
- R8: A `mb_start` in the idle state yields exactly one single-cycle `qp_valid` pulse. A `mb_start` that arrives while a QP is still being computed is ignored.
- R9: Every issued QP is in the range 1 to 31. A requested QP of 0 is raised to 1 before the ±2 limit.
- R10: When the used complexity is zero, the requested QP equals the previous QP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_start | input | 1 | Load frame totals and frame QP |
| frm_cplx | input | CW | Total frame complexity |
| frm_bits | input | BW | Frame bit budget |
| frm_qp | input | 5 | Starting QP of the frame |
| mb_start | input | 1 | Request a QP for the next macroblock |
| mb_mode | input | 2 | Macroblock coding mode (see R5) |
| mb_done | input | 1 | Macroblock coded; totals update |
| mb_cplx | input | CW | SAD (inter) or deviation (intra) of the coded macroblock |
| mb_bits | input | BW | Actual bits of the coded macroblock |
| qp_valid | output | 1 | Single-cycle pulse: `qp_out` holds a new QP |
| qp_out | output | 5 | QP for the requested macroblock |

## Verification
Directed frames cover several cases. The second macroblock requests well above the frame QP, which shows the ratio formula and the +2 limit working together. A not-coded macroblock follows, which shows that the hold rule overrides the ratio. A frame ends in bit overspend to drive the saturate-to-31 path. Another frame starts with a QP of 0 and reports zero SAD, which separates the zero-used-complexity path from the divide. A SAD larger than the remaining complexity pushes the requested QP to zero. A second start is injected during a divide to show that it yields no second pulse. Seeded random frames then mix all four modes with a wide spread of SAD and bit counts. Each QP is compared with a bench model of the running totals, so an error in any accumulator shows up in the QPs that follow.

// File: rtl/mbq_pkg.sv
package mbq_pkg;
  localparam int QP_W    = 5;
  localparam int QP_MIN  = 1;
  localparam int QP_MAX  = 31;
  localparam int QP_STEP = 2;

  typedef enum logic [1:0] {
    MB_INTER    = 2'b00,
    MB_INTRA    = 2'b01,
    MB_SKIP     = 2'b10,
    MB_INTER4MV = 2'b11
  } mb_mode_e;
endpackage

// File: rtl/mbq_accum.sv
module mbq_accum
  import mbq_pkg::*;
#(
  parameter int CW  = 16,
  parameter int BW  = 16,
  parameter int MBW = 7,
  localparam int RW  = BW + MBW + 1,
  localparam int UCW = CW + MBW,
  localparam int UBW = BW + MBW,
  localparam int QW  = QP_W + MBW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [CW-1:0]        frm_cplx,
  input  logic [BW-1:0]        frm_bits,
  input  logic                 upd,
  input  logic [CW-1:0]        mb_cplx,
  input  logic [BW-1:0]        mb_bits,
  input  logic [QP_W-1:0]      mb_qp,
  output logic [CW-1:0]        c_rem,
  output logic signed [RW-1:0] r_rem,
  output logic [UCW-1:0]       c_used,
  output logic [UBW-1:0]       r_used,
  output logic [QW-1:0]        q_used,
  output logic [MBW-1:0]       n_done
);
  always_ff @(posedge clk) begin
    if (rst || load) begin
      c_rem  <= rst ? '0 : frm_cplx;
      r_rem  <= rst ? '0 : $signed({{(MBW+1){1'b0}}, frm_bits});
      c_used <= '0;
      r_used <= '0;
      q_used <= '0;
      n_done <= '0;
    end else if (upd) begin
      c_rem  <= (mb_cplx >= c_rem) ? '0 : c_rem - mb_cplx;
      r_rem  <= r_rem - $signed({{(MBW+1){1'b0}}, mb_bits});
      c_used <= c_used + UCW'(mb_cplx);
      r_used <= r_used + UBW'(mb_bits);
      q_used <= q_used + QW'(mb_qp);
      n_done <= n_done + 1'b1;
    end
  end

  // Remaining plus used bits stays fixed across an update
  logic signed [RW:0] bit_sum;
  assign bit_sum = $signed({r_rem[RW-1], r_rem}) + $signed({2'b00, r_used});

  p_bits_conserve_r7: assert property (@(posedge clk) disable iff (rst)
    (upd && !load) |=> (bit_sum == $past(bit_sum)));

  p_qsum_grows_r7: assert property (@(posedge clk) disable iff (rst)
    (upd && !load && mb_qp != '0) |=> (q_used > $past(q_used)));
endmodule

// File: rtl/mbq_div.sv
module mbq_div #(
  parameter int NW = 51,
  parameter int DW = 46,
  localparam int CNW = $clog2(NW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          busy,
  output logic          done,
  output logic [NW-1:0] quot
);
  logic [NW-1:0]  q_r, num_r;
  logic [DW-1:0]  den_r, rem_r;
  logic [CNW-1:0] cnt;
  logic [DW:0]    trial;
  logic           fits;

  assign trial = {rem_r, q_r[NW-1]};
  assign fits  = trial >= {1'b0, den_r};
  assign quot  = q_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt   <= '0;
      q_r   <= '0;
      num_r <= '0;
      den_r <= '0;
      rem_r <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        q_r   <= num;
        num_r <= num;
        den_r <= den;
        rem_r <= '0;
        cnt   <= CNW'(NW);
        busy  <= 1'b1;
      end else if (busy) begin
        rem_r <= fits ? DW'(trial - {1'b0, den_r}) : trial[DW-1:0];
        q_r   <= {q_r[NW-2:0], fits};
        cnt   <= cnt - 1'b1;
        if (cnt == CNW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  p_den_nonzero_r10: assert property (@(posedge clk) disable iff (rst)
    start |-> (den != '0));

  p_div_exact_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> ((NW+DW)'(q_r) * (NW+DW)'(den_r) + (NW+DW)'(rem_r) == (NW+DW)'(num_r))
             && (rem_r < den_r));
endmodule

// File: rtl/mbq_limit.sv
module mbq_limit
  import mbq_pkg::*;
(
  input  logic [QP_W-1:0] req,
  input  logic [QP_W-1:0] prev,
  input  logic            hold,
  input  logic            first,
  output logic [QP_W-1:0] qp
);
  logic [QP_W:0] rc, lo, hi;

  always_comb begin
    rc = (req < QP_W'(QP_MIN)) ? (QP_W+1)'(QP_MIN) : {1'b0, req};
    lo = ({1'b0, prev} > (QP_W+1)'(QP_MIN + QP_STEP)) ?
         {1'b0, prev} - (QP_W+1)'(QP_STEP) : (QP_W+1)'(QP_MIN);
    hi = ({1'b0, prev} + (QP_W+1)'(QP_STEP) > (QP_W+1)'(QP_MAX)) ?
         (QP_W+1)'(QP_MAX) : {1'b0, prev} + (QP_W+1)'(QP_STEP);
    if (first)      qp = rc[QP_W-1:0];
    else if (hold)  qp = prev;
    else if (rc < lo) qp = lo[QP_W-1:0];
    else if (rc > hi) qp = hi[QP_W-1:0];
    else            qp = rc[QP_W-1:0];
  end
endmodule

// File: rtl/mbq_ctrl.sv
module mbq_ctrl
  import mbq_pkg::*;
#(
  parameter int CW      = 16,
  parameter int BW      = 16,
  parameter int MAX_MBS = 99
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            frm_start,
  input  logic [CW-1:0]   frm_cplx,
  input  logic [BW-1:0]   frm_bits,
  input  logic [QP_W-1:0] frm_qp,
  input  logic            mb_start,
  input  logic [1:0]      mb_mode,
  input  logic            mb_done,
  input  logic [CW-1:0]   mb_cplx,
  input  logic [BW-1:0]   mb_bits,
  output logic            qp_valid,
  output logic [QP_W-1:0] qp_out
);
  localparam int MBW = $clog2(MAX_MBS + 1);
  localparam int RW  = BW + MBW + 1;
  localparam int UCW = CW + MBW;
  localparam int UBW = BW + MBW;
  localparam int QW  = QP_W + MBW;
  localparam int NW  = CW + UBW + QW;
  localparam int DW  = UCW + BW + MBW;

  typedef enum logic [1:0] {S_IDLE, S_DIV, S_FIN} st_e;

  st_e              st;
  mb_mode_e         mode_q;
  logic             first_q;
  logic [QP_W-1:0]  req_q, prev_qp, lim_qp;
  logic             hold_q;

  logic [CW-1:0]        c_rem;
  logic signed [RW-1:0] r_rem;
  logic [UCW-1:0]       c_used;
  logic [UBW-1:0]       r_used;
  logic [QW-1:0]        q_used;
  logic [MBW-1:0]       n_done;

  logic          div_start, div_busy, div_done;
  logic [NW-1:0] div_num, div_quot;
  logic [DW-1:0] div_den;

  mbq_accum #(.CW(CW), .BW(BW), .MBW(MBW)) u_accum (
    .clk(clk), .rst(rst), .load(frm_start), .frm_cplx(frm_cplx), .frm_bits(frm_bits),
    .upd(mb_done), .mb_cplx(mb_cplx), .mb_bits(mb_bits), .mb_qp(prev_qp),
    .c_rem(c_rem), .r_rem(r_rem), .c_used(c_used), .r_used(r_used),
    .q_used(q_used), .n_done(n_done)
  );

  assign div_num = NW'(c_rem) * NW'(r_used) * NW'(q_used);
  assign div_den = DW'(c_used) * DW'(r_rem[BW-1:0]) * DW'(n_done);

  mbq_div #(.NW(NW), .DW(DW)) u_div (
    .clk(clk), .rst(rst), .start(div_start), .num(div_num), .den(div_den),
    .busy(div_busy), .done(div_done), .quot(div_quot)
  );

  assign hold_q = (mode_q == MB_SKIP) || (mode_q == MB_INTER4MV);

  mbq_limit u_limit (
    .req(req_q), .prev(prev_qp), .hold(hold_q), .first(first_q), .qp(lim_qp)
  );

  logic go;
  assign go = (st == S_IDLE) && mb_start && !frm_start;
  assign div_start = go && (n_done != '0) && (r_rem > 0) && (c_used != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      mode_q   <= MB_INTER;
      first_q  <= 1'b1;
      req_q    <= QP_W'(QP_MIN);
      prev_qp  <= QP_W'(QP_MIN);
      qp_out   <= '0;
      qp_valid <= 1'b0;
    end else begin
      qp_valid <= 1'b0;
      if (frm_start) begin
        st      <= S_IDLE;
        prev_qp <= (frm_qp < QP_W'(QP_MIN)) ? QP_W'(QP_MIN) : frm_qp;
      end else begin
        case (st)
          S_IDLE: if (go) begin
            mode_q  <= mb_mode_e'(mb_mode);
            first_q <= (n_done == '0);
            if (div_start) begin
              st <= S_DIV;
            end else begin
              req_q <= (n_done != '0 && !(r_rem > 0)) ? QP_W'(QP_MAX) : prev_qp;
              st    <= S_FIN;
            end
          end
          S_DIV: if (div_done) begin
            req_q <= (div_quot > NW'(QP_MAX)) ? QP_W'(QP_MAX) : div_quot[QP_W-1:0];
            st    <= S_FIN;
          end
          S_FIN: begin
            qp_out   <= lim_qp;
            prev_qp  <= lim_qp;
            qp_valid <= 1'b1;
            st       <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  p_range_r9: assert property (@(posedge clk) disable iff (rst)
    qp_valid |-> (qp_out >= QP_W'(QP_MIN)) && (qp_out <= QP_W'(QP_MAX)));

  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    (qp_valid && !first_q && !$past(frm_start)) |->
      (({1'b0, qp_out} + 6'd2 >= {1'b0, $past(prev_qp)}) &&
       ({1'b0, qp_out} <= {1'b0, $past(prev_qp)} + 6'd2)));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (qp_valid && !first_q && hold_q && !$past(frm_start)) |-> (qp_out == $past(prev_qp)));

  p_first_r2: assert property (@(posedge clk) disable iff (rst)
    (qp_valid && first_q && !$past(frm_start)) |-> (qp_out == $past(prev_qp)));

  p_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    qp_valid |=> !qp_valid);
endmodule

// File: tb/mbq_ctrl_tb.sv
module mbq_ctrl_tb;
  localparam int CW = 16;
  localparam int BW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frm_start = 1'b0, mb_start = 1'b0, mb_done = 1'b0;
  logic [CW-1:0] frm_cplx = '0, mb_cplx = '0;
  logic [BW-1:0] frm_bits = '0, mb_bits = '0;
  logic [4:0] frm_qp = '0;
  logic [1:0] mb_mode = '0;
  logic qp_valid;
  logic [4:0] qp_out;

  always #2.5 clk = ~clk;

  mbq_ctrl #(.CW(CW), .BW(BW), .MAX_MBS(99)) u_dut (
    .clk(clk), .rst(rst), .frm_start(frm_start), .frm_cplx(frm_cplx),
    .frm_bits(frm_bits), .frm_qp(frm_qp), .mb_start(mb_start), .mb_mode(mb_mode),
    .mb_done(mb_done), .mb_cplx(mb_cplx), .mb_bits(mb_bits),
    .qp_valid(qp_valid), .qp_out(qp_out)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  longint m_crem, m_rrem, m_cused, m_rused, m_qused, m_n, m_prev;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint exp_qp(input logic [1:0] mode);
    longint req, lo, hi;
    if (m_n == 0) return m_prev;                       // R2
    if (m_rrem <= 0) req = 31;                         // R6
    else if (m_cused == 0) req = m_prev;               // R10
    else begin
      req = (m_crem * m_rused * m_qused) / (m_cused * m_rrem * m_n);  // R3
      if (req > 31) req = 31;
    end
    if (mode == 2'b10 || mode == 2'b11) return m_prev; // R5
    if (req < 1) req = 1;                              // R9
    lo = (m_prev - 2 < 1) ? 1 : m_prev - 2;            // R4
    hi = (m_prev + 2 > 31) ? 31 : m_prev + 2;
    if (req < lo) req = lo;
    if (req > hi) req = hi;
    return req;
  endfunction

  task automatic new_frame(input int c, input int b, input int q);
    @(negedge clk);
    frm_start = 1'b1; frm_cplx = CW'(c); frm_bits = BW'(b); frm_qp = 5'(q);
    @(negedge clk);
    frm_start = 1'b0;
    m_crem = c; m_rrem = b; m_cused = 0; m_rused = 0; m_qused = 0; m_n = 0;
    m_prev = (q == 0) ? 1 : q;
  endtask

  task automatic do_mb(input logic [1:0] mode, input int sad, input int bits,
                       input string tag, input bit poke);
    longint e;
    int pulses, got;
    e = exp_qp(mode);
    @(negedge clk);
    mb_start = 1'b1; mb_mode = mode;
    @(negedge clk);
    mb_start = 1'b0;
    pulses = 0; got = -1;
    for (int i = 0; i < 120; i++) begin
      if (qp_valid) begin pulses++; got = int'(qp_out); end
      mb_start = (poke && i == 3);
      @(negedge clk);
    end
    mb_start = 1'b0;
    chk(tag, got, e);
    if (poke) chk("R8 pulse count", pulses, 1);
    m_prev = e;
    mb_done = 1'b1; mb_cplx = CW'(sad); mb_bits = BW'(bits);
    @(negedge clk);
    mb_done = 1'b0;
    // R7 bench model of the running totals
    m_crem  = (sad >= m_crem) ? 0 : m_crem - sad;
    m_rrem  = m_rrem - bits;
    m_cused = m_cused + sad;
    m_rused = m_rused + bits;
    m_qused = m_qused + e;
    m_n     = m_n + 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 qp_valid after reset", qp_valid, 0);
    chk("R1 qp_out after reset", qp_out, 0);

    // Directed frame: ratio, step limit, hold, busy poke, overspend
    new_frame(1000, 2000, 10);
    do_mb(2'b00, 100, 300, "R2 first mb frame qp", 1'b0);
    do_mb(2'b00, 100, 100, "R3 R4 ratio with +2 limit", 1'b0);
    do_mb(2'b10, 50, 40, "R5 not-coded holds qp", 1'b0);
    do_mb(2'b01, 120, 200, "R3 intra ratio", 1'b1);
    do_mb(2'b11, 80, 5000, "R5 four-vector holds qp", 1'b0);
    do_mb(2'b00, 60, 100, "R6 overspend saturates", 1'b0);
    do_mb(2'b00, 60, 100, "R6 overspend again", 1'b0);

    // Zero QP frame, zero SAD, then complexity exhausted
    new_frame(50, 4000, 0);
    do_mb(2'b00, 0, 10, "R2 frame qp 0 raised to 1", 1'b0);
    do_mb(2'b00, 80, 10, "R10 zero used complexity", 1'b0);
    do_mb(2'b01, 10, 10, "R9 zero request raised", 1'b0);

    new_frame(3000, 1000, 31);
    do_mb(2'b00, 500, 50, "R2 frame qp 31", 1'b0);
    do_mb(2'b00, 500, 50, "R4 downward step limit", 1'b0);
    do_mb(2'b00, 500, 50, "R4 downward step again", 1'b0);

    // Seeded random frames: R3 R7 R9 via the model
    for (int f = 0; f < 20; f++) begin
      new_frame($urandom_range(30000, 1000), $urandom_range(40000, 2000),
                $urandom_range(31, 0));
      for (int m = 0; m < 8; m++) begin
        do_mb(2'($urandom_range(3, 0)), $urandom_range(2000, 0),
              $urandom_range(3000, 0), "R3 R7 R9 random", 1'b0);
      end
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule